// File: doc/BRIEF.md
# Seven-Master Bus Arbiter with Interrupt Priority Boost

This block decides which of seven masters owns a shared system bus. Each master has a request line and a grant line. The masters are an audio controller, two general DMA engines, an Ethernet DMA, a USB host, a USB device and the CPU. Once a master holds the bus it keeps it until it drops its own request. Only then is the next owner chosen. At most one grant line is high at any time.

A 32-bit control register sets the scheme. It selects fixed or rotating priority and enables a CPU boost. The boost works as follows: when it is enabled and an unmasked interrupt is pending, a sticky flag is set. While the flag is set, the CPU is lifted from the last place to second place, just below the audio controller. The flag stays set until software writes 0 to it.

The control state machine has two states. In `ST_IDLE` no grant is driven. The transition `IDLE_TO_OWN` is taken on a clock edge when any request is present, and it registers the winner as the owner. In `ST_OWN` the owner's grant is driven. `OWN_HOLD` keeps the state while the owner still requests. `OWN_TO_IDLE` is taken when the owner drops its request. This leaves one grant-free cycle between owners.

Top module: `bus_arbiter7`

## Requirements
- R1: At most one bit of `gnt_o` is 1 in every cycle.
- R2: While the owner keeps its request high, its grant stays high and no other master is granted. One clock after the owner drops its request, all grants are 0. The next grant follows one clock after that.
- R3: After reset, `gnt_o` is 0, `cfg_rdata_o` reads 0, and fixed-priority mode is active.
- R4: Master indices are 0 audio, 1 DMA0, 2 DMA1, 3 Ethernet DMA, 4 USB host, 5 USB device and 6 CPU. In fixed mode with the boost inactive, the lowest requesting index wins.
- R5: The boost enable is control bit 1. When it is 0, `irq_i` never sets the flag, and the CPU (index 6) stays lowest even if the flag was set earlier.
- R6: The boost flag is control bit 2. With bit 1 at 1, `irq_i` high at a clock edge sets the flag at that edge. When the flag and the enable are both 1 in fixed mode, the order is 0, 6, 1, 2, 3, 4, 5.
- R7: The flag stays set after `irq_i` falls. A write with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R8: Control bit 0 is the mode: 0 is fixed and 1 is rotating. In rotating mode the search starts at the index after the most recently granted master and wraps circularly. After reset that search starts at index 0.
- R9: Control bits 31 to 3 always read 0, whatever is written to them.
- R10: When the bus is idle, a request present at a clock edge produces its grant at that edge. A grant is only ever driven to a master whose request was high at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 7 | Bus requests, one per master (index order as in R4) |
| irq_i | input | 1 | Unmasked interrupt pending |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wdata_i | input | 32 | Control register write data |
| cfg_rdata_o | output | 32 | Control register read data |
| gnt_o | output | 7 | Bus grants, one-hot or zero |

## Verification
On every cycle the assertions check three properties of the grants: they are one-hot or zero, an owner keeps its grant while it still requests, and no grant goes to a master that was not requesting. They also check, every cycle, that the boost flag is set by an enabled interrupt and stays set until a clearing write. The priority orders themselves need the bench's scenarios: the fixed order with the boost on and off, the rotation sequence, the one idle cycle at hand-over, the set-over-clear race and the reads of the unused bits.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int unsigned CTRL_W    = 32;
    localparam int unsigned BIT_MODE  = 0;
    localparam int unsigned BIT_BEN   = 1;
    localparam int unsigned BIT_BFLAG = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OWN  = 1'b1
    } arb_state_e;
endpackage

// File: rtl/arb_ctrl_reg.sv
module arb_ctrl_reg
    import arb_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              irq_i,
    output logic [CTRL_W-1:0] rdata_o,
    output logic              rotate_o,
    output logic              boost_o
);
    logic mode_q, ben_q, flag_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q <= 1'b0;
            ben_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (we_i) begin
                mode_q <= wdata_i[BIT_MODE];
                ben_q  <= wdata_i[BIT_BEN];
            end
            // set has precedence over a software clear
            if (ben_q && irq_i)
                flag_q <= 1'b1;
            else if (we_i && !wdata_i[BIT_BFLAG])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        rdata_o            = '0;
        rdata_o[BIT_MODE]  = mode_q;
        rdata_o[BIT_BEN]   = ben_q;
        rdata_o[BIT_BFLAG] = flag_q;
    end

    assign rotate_o = mode_q;
    assign boost_o  = ben_q & flag_q;

    // R6: enabled interrupt sets the flag at the same edge
    assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ben_q && irq_i) |=> flag_q);

    // R7: flag only falls through a clearing write
    assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q && !(we_i && !wdata_i[BIT_BFLAG])) |=> flag_q);
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int unsigned N  = 7,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    input  logic          rotate_i,
    input  logic          boost_i,
    input  logic [IW-1:0] last_i,
    output logic          any_o,
    output logic [IW-1:0] win_o
);
    // slot k of the fixed order -> master index; boost moves the last master to slot 1
    function automatic int fixed_slot(int k, logic b);
        if (!b)      return k;
        if (k == 0)  return 0;
        if (k == 1)  return int'(N) - 1;
        return k - 1;
    endfunction

    always_comb begin
        any_o = |req_i;
        win_o = '0;
        // walk from lowest priority to highest so the highest hit remains
        for (int k = int'(N) - 1; k >= 0; k--) begin
            int idx;
            if (rotate_i)
                idx = (int'(last_i) + 1 + k) % int'(N);
            else
                idx = fixed_slot(k, boost_i);
            if (req_i[idx])
                win_o = IW'(idx);
        end
    end
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
#(
    parameter int unsigned N  = 7,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [N-1:0]  req_i,
    input  logic          any_i,
    input  logic [IW-1:0] win_i,
    output logic [IW-1:0] owner_o,
    output logic [N-1:0]  gnt_o
);
    arb_state_e    state_q, state_d;
    logic [IW-1:0] owner_q, owner_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            owner_q <= IW'(N - 1);
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ST_IDLE: if (any_i) begin
                state_d = ST_OWN;
                owner_d = win_i;
            end
            ST_OWN: if (!req_i[owner_q]) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign owner_o = owner_q;

    for (genvar g = 0; g < N; g++) begin : g_gnt
        assign gnt_o[g] = (state_q == ST_OWN) && (owner_q == IW'(g));

        // R2: a held request keeps its grant
        assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (gnt_o[g] && req_i[g]) |=> gnt_o[g]);

        // R10: grant only to a master that requested at the previous edge
        assert_gnt_has_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ##1 gnt_o[g] |-> $past(req_i[g]));
    end

    // R1: never more than one grant
    assert_onehot_grant_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));
endmodule

// File: rtl/bus_arbiter7.sv
module bus_arbiter7
    import arb_pkg::*;
#(
    parameter int unsigned N_MASTERS = 7
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 irq_i,
    input  logic                 cfg_we_i,
    input  logic [CTRL_W-1:0]    cfg_wdata_i,
    output logic [CTRL_W-1:0]    cfg_rdata_o,
    output logic [N_MASTERS-1:0] gnt_o
);
    localparam int unsigned IW = $clog2(N_MASTERS);

    logic          rotate, boost, any;
    logic [IW-1:0] win, owner;

    arb_ctrl_reg i_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (cfg_we_i),
        .wdata_i  (cfg_wdata_i),
        .irq_i    (irq_i),
        .rdata_o  (cfg_rdata_o),
        .rotate_o (rotate),
        .boost_o  (boost)
    );

    arb_pick #(.N(N_MASTERS), .IW(IW)) i_pick (
        .req_i    (req_i),
        .rotate_i (rotate),
        .boost_i  (boost),
        .last_i   (owner),
        .any_o    (any),
        .win_o    (win)
    );

    arb_fsm #(.N(N_MASTERS), .IW(IW)) i_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (req_i),
        .any_i   (any),
        .win_i   (win),
        .owner_o (owner),
        .gnt_o   (gnt_o)
    );
endmodule

// File: tb/test_bus_arbiter7.sv
`timescale 1ns/1ps
module test_bus_arbiter7;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [6:0]  req = '0;
    logic        irq = 0;
    logic        we = 0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [6:0]  gnt;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    bus_arbiter7 i_bus_arbiter7 (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .irq_i(irq),
        .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .gnt_o(gnt)
    );

    typedef struct packed {
        logic       en;
        logic       irq;
        logic [6:0] req;
        logic [6:0] exp;
    } vec_t;

    // fixed-mode vectors: boost enable, interrupt pulse, requests, expected grant
    localparam vec_t VECS[10] = '{
        '{1'b0, 1'b0, 7'b1111111, 7'b0000001},  // R4
        '{1'b0, 1'b0, 7'b1000010, 7'b0000010},  // R4
        '{1'b0, 1'b1, 7'b1000100, 7'b0000100},  // R5
        '{1'b1, 1'b1, 7'b1000010, 7'b1000000},  // R6
        '{1'b1, 1'b1, 7'b1000001, 7'b0000001},  // R6
        '{1'b1, 1'b0, 7'b1000010, 7'b0000010},  // R6 no irq
        '{1'b0, 1'b0, 7'b0110000, 7'b0010000},  // R4
        '{1'b1, 1'b1, 7'b0100000, 7'b0100000},  // R6
        '{1'b0, 1'b0, 7'b0000000, 7'b0000000},  // R10
        '{1'b1, 1'b1, 7'b1111110, 7'b1000000}   // R6
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] d);
        @(negedge clk); we = 1; wdata = d;
        @(negedge clk); we = 0; wdata = '0;
    endtask

    task automatic request(logic [6:0] r, logic [6:0] e, string tag);
        @(negedge clk); req = r;
        @(negedge clk); chk(tag, {25'b0, gnt}, {25'b0, e});
    endtask

    task automatic release_all();
        @(negedge clk); req = '0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; req = '0; irq = 0; we = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk("R3 grant at reset", {25'b0, gnt}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk("R3 ctrl at reset", rdata, 32'h0);

        // vector table walk
        for (int i = 0; i < 10; i++) begin
            wr({30'b0, VECS[i].en, 1'b0});  // flag cleared, fixed mode
            @(negedge clk); irq = VECS[i].irq;
            @(negedge clk); irq = 0;
            request(VECS[i].req, VECS[i].exp, $sformatf("R4/R5/R6 vector %0d", i));
            release_all();
        end

        // R2: owner keeps bus; hand-over after one idle cycle
        wr(32'h0);
        request(7'b1000000, 7'b1000000, "R2 cpu granted alone");
        @(negedge clk); req = 7'b1000001;
        @(negedge clk); @(negedge clk);
        chk("R2 cpu still owns", {25'b0, gnt}, {25'b0, 7'b1000000});
        req = 7'b0000001;
        @(negedge clk);
        chk("R2 idle cycle", {25'b0, gnt}, 32'h0);
        @(negedge clk);
        chk("R2 audio after release", {25'b0, gnt}, 32'h1);
        release_all();

        // R5: flag set earlier but enable cleared -> cpu lowest
        wr(32'h2);
        @(negedge clk); irq = 1; @(negedge clk); irq = 0;
        wr(32'h4);  // en=0, flag write 1 no effect
        chk("R5 flag kept, en off", rdata, 32'h4);
        request(7'b1000010, 7'b0000010, "R5 cpu lowest when disabled");
        release_all();

        // R7: sticky flag, write 1 no effect, write 0 clears, set wins
        wr(32'h2);
        @(negedge clk); irq = 1; @(negedge clk); irq = 0;
        @(negedge clk); @(negedge clk);
        chk("R7 flag sticky", rdata, 32'h6);
        wr(32'h6);
        chk("R7 write 1 no effect", rdata, 32'h6);
        wr(32'h2);
        chk("R7 write 0 clears", rdata, 32'h2);
        @(negedge clk); irq = 1; we = 1; wdata = 32'h2;
        @(negedge clk); irq = 0; we = 0; wdata = '0;
        chk("R7 set wins over clear", rdata, 32'h6);

        // R9: unused bits read 0
        wr(32'h0);
        wr(32'hFFFF_FFFB);
        chk("R9 unused bits zero", rdata, 32'h3);

        // R8: rotating order from reset
        do_reset();
        wr(32'h1);
        request(7'b0000101, 7'b0000001, "R8 rotate first");
        release_all();
        request(7'b0000101, 7'b0000100, "R8 rotate second");
        release_all();
        request(7'b0000101, 7'b0000001, "R8 rotate wrap");
        release_all();
        request(7'b1000001, 7'b1000000, "R8 rotate after 0");
        release_all();
        request(7'b1000001, 7'b0000001, "R8 rotate after 6");
        release_all();
        chk("R1 no grant when idle", {25'b0, gnt}, 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule